// File: doc/BRIEF.md
# Per-element predicate issue sequencer

This block walks a predicated vector operation from element 0 up to VL-1. At each step it hands a Function Unit three things: the element index, the unit slot it belongs to, and a lane mask of predicate bits. No separate predicate unit sits between the condition storage and the execution units. The predicate source is a single 32-bit word made of eight 4-bit condition fields. That word is taken in one wide read when the operation starts. Predicate bits are then handed out per element, straight from those fields.

How the fields are split depends on the element width:

- **8-bit elements:** all eight fields go with one issue to one unit.
- **16-bit elements:** one issue feeds an even/odd pair of units at the same moment. The even unit gets fields 0 to 3 and the odd unit gets fields 4 to 7, so one read is broadcast to both.
- **32-bit elements:** each unit receives two single-field predicates, one for the low half and one for the high half.
- **64-bit elements:** one field is used per issue.

When predication is off, every active lane is forced to 1. Lanes past VL are always 0.

Top module: `pred_issue_seq`

## Requirements
- R1: After reset, `vld` is 0 and stays 0 until a start pulse with nonzero `vl` is taken.
- R2: A `start` sampled at a clock edge latches `vl`, `ew`, `pred_en`, `bit_sel`, `pred_inv` and `cond_word`. If `vl` is nonzero, `vld` is 1 from the next cycle with `elem_idx` = 0 and `fu_slot` = 0. If `vl` is 0, `vld` stays 0.
- R3: Each accepted issue (`vld` and `rdy` high at an edge) advances `elem_idx` by 8, 8, 2 or 1 for `ew` codes 0 (8-bit), 1 (16-bit), 2 (32-bit) and 3 (64-bit).
- R4: While `vld` is 1 and `rdy` is 0, `elem_idx`, `fu_slot`, `pair` and `lane_mask` hold their values.
- R5: With predication on, `lane_mask[i]` for an active lane equals bit `bit_sel` of condition field (`elem_idx`+i) mod 8, XOR `pred_inv`. Field j occupies `cond_word[4j+3:4j]`.
- R6: With `pred_en` = 0, every active lane of `lane_mask` is 1.
- R7: Lane i is active only if i is below the lanes per issue (8, 8, 2, 1 for `ew` 0..3) and `elem_idx`+i < `vl`. Inactive lanes read 0.
- R8: Slot assignment depends on the element width:
  - For `ew` 1, `pair` is 1 and lanes 0-3 belong to unit `fu_slot` (always even) while lanes 4-7 belong to unit `fu_slot`+1; the slot then advances by 2.
  - For the other widths, `pair` is 0 and the slot advances by 1.
  - In both cases the slot count is modulo NFU.
- R9: The issue in which `elem_idx` + step reaches or passes `vl` is the last one. Once it is accepted, `vld` falls. A `start` while busy restarts at element 0 with the new settings.
- R10: Changes on `cond_word` or on the other settings after the start edge have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new operation, latching the settings |
| vl | input | VLW | Vector length in elements |
| ew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| pred_en | input | 1 | Predication enable |
| bit_sel | input | 2 | Which bit of each 4-bit field is the predicate |
| pred_inv | input | 1 | Complement the selected predicate bit |
| cond_word | input | 32 | Eight 4-bit condition fields, field j at bits 4j+3:4j |
| rdy | input | 1 | Target unit accepts the current issue |
| vld | output | 1 | An issue is presented |
| elem_idx | output | VLW | First element index of the issue |
| fu_slot | output | log2(NFU) | Target unit slot (even unit when paired) |
| pair | output | 1 | Issue is broadcast to units `fu_slot` and `fu_slot`+1 |
| lane_mask | output | 8 | Per-lane predicate mask |

## Verification
The hardest cases to reach from the ports are the short final groups. These occur when `vl` is not a multiple of the step, so the last issue has only some lanes inside VL. Their field index can also wrap past field 7 when the width is 32 or 64 bits. The stimulus sweeps every `vl` from 0 to 20 under all four widths, both predicate polarities and every bit selector. `rdy` is stalled on a pseudo-random pattern and `cond_word` is scrambled right after each start. A separate pass restarts an operation in mid-flight.

// File: rtl/pred_issue_seq.sv
module pred_issue_seq #(
  parameter int VLW = 8,
  parameter int NFU = 4,
  localparam int SW = (NFU > 2) ? $clog2(NFU) : 1,
  localparam int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [1:0]       ew,
  input  logic             pred_en,
  input  logic [1:0]       bit_sel,
  input  logic             pred_inv,
  input  logic [31:0]      cond_word,
  input  logic             rdy,
  output logic             vld,
  output logic [VLW-1:0]   elem_idx,
  output logic [SW-1:0]    fu_slot,
  output logic             pair,
  output logic [LANES-1:0] lane_mask
);

  logic           busy;
  logic [VLW-1:0] cnt, vl_q;
  logic [SW-1:0]  slot;
  logic [1:0]     ew_q, bs_q;
  logic           pen_q, inv_q;
  logic [31:0]    cw_q;

  logic [3:0]     step;
  logic [VLW:0]   nxt;
  logic           last;

  always_comb begin
    case (ew_q)
      2'd0, 2'd1: step = 4'd8;
      2'd2:       step = 4'd2;
      default:    step = 4'd1;
    endcase
  end

  assign nxt  = {1'b0, cnt} + {{(VLW-3){1'b0}}, step};
  assign last = nxt >= {1'b0, vl_q};

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [VLW:0] e;
      logic         act, pb;
      e   = {1'b0, cnt} + (VLW+1)'(i);
      act = (i < int'(step)) && (e < {1'b0, vl_q});
      pb  = cw_q[{e[2:0], bs_q}] ^ inv_q;
      lane_mask[i] = act & (pen_q ? pb : 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      slot  <= '0;
      vl_q  <= '0;
      ew_q  <= 2'd0;
      bs_q  <= 2'd0;
      pen_q <= 1'b0;
      inv_q <= 1'b0;
      cw_q  <= '0;
    end else if (start) begin
      busy  <= vl != '0;
      cnt   <= '0;
      slot  <= '0;
      vl_q  <= vl;
      ew_q  <= ew;
      bs_q  <= bit_sel;
      pen_q <= pred_en;
      inv_q <= pred_inv;
      cw_q  <= cond_word;
    end else if (busy && rdy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= nxt[VLW-1:0];
      slot <= slot + ((ew_q == 2'd1) ? SW'(2) : SW'(1));
    end
  end

  assign vld      = busy;
  assign elem_idx = cnt;
  assign fu_slot  = slot;
  assign pair     = ew_q == 2'd1;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !vld);
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start && vl != '0 |=> vld && elem_idx == '0 && fu_slot == '0);
  a_r2_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start && vl == '0 |=> !vld);
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy && !start |=> vld && $stable(elem_idx) && $stable(fu_slot) && $stable(lane_mask));
  a_r7_idx_inside: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> elem_idx < vl_q && lane_mask[0] == (pen_q ? (cw_q[{elem_idx[2:0], bs_q}] ^ inv_q) : 1'b1));
  a_r8_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    vld && pair |-> fu_slot[0] == 1'b0 || SW == 1);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    vld && rdy && !start && last |=> !vld);

endmodule

// File: tb/pred_issue_seq_test.sv
module pred_issue_seq_test;
  localparam int VLW = 8, NFU = 4, SW = 2;

  logic clk = 0, rst_n = 0, start = 0, pred_en = 0, pred_inv = 0, rdy = 0;
  logic [VLW-1:0] vl = '0;
  logic [1:0] ew = 0, bit_sel = 0;
  logic [31:0] cond_word = '0;
  logic vld, pair;
  logic [VLW-1:0] elem_idx;
  logic [SW-1:0] fu_slot;
  logic [7:0] lane_mask;

  int checks = 0, fails = 0;
  bit done = 0;

  pred_issue_seq #(.VLW(VLW), .NFU(NFU)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int per_issue(input int w);
    return (w <= 1) ? 8 : (w == 2) ? 2 : 1;
  endfunction

  function automatic logic [7:0] exp_mask(input int w, input int idx, input int n,
      input bit pe, input int bs, input bit inv, input logic [31:0] cw);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++)
      if (i < per_issue(w) && idx + i < n)
        m[i] = pe ? (cw[4*((idx+i)%8)+bs] ^ inv) : 1'b1;
    return m;
  endfunction

  // Runs one operation; stops after max_iss accepted issues (operation may stay busy).
  task automatic run_op(input int w, input int n, input bit pe, input int bs,
      input bit inv, input logic [31:0] cw, input int max_iss);
    int idx = 0, slot = 0, iss = 0;
    bit prev_stall = 0;
    @(negedge clk);
    start = 1; vl = VLW'(n); ew = 2'(w); pred_en = pe; bit_sel = 2'(bs);
    pred_inv = inv; cond_word = cw; rdy = 0;
    @(negedge clk);
    start = 0;
    cond_word = ~cw; pred_en = ~pe; bit_sel = ~2'(bs); pred_inv = ~inv; ew = ~2'(w); vl = ~VLW'(n);
    if (n == 0) begin
      chk(vld == 0, "R2 empty vl idle", vld, 0);
      @(negedge clk);
      chk(vld == 0, "R2 empty vl stays idle", vld, 0);
      return;
    end
    while (idx < n && iss < max_iss) begin
      logic [7:0] em;
      em = exp_mask(w, idx, n, pe, bs, inv, cw);
      chk(vld == 1, prev_stall ? "R4 vld held in stall" : (idx == 0 ? "R2 vld after start" : "R3 vld"), vld, 1);
      chk(elem_idx == VLW'(idx), prev_stall ? "R4 idx held" : "R3 elem_idx", elem_idx, idx);
      chk(fu_slot == SW'(slot) && pair == (w == 1), "R8 slot/pair", {fu_slot, pair}, {slot[SW-1:0], w == 1});
      chk(lane_mask == em, pe ? "R5 R7 R10 lane_mask" : "R6 R7 lane_mask", lane_mask, em);
      rdy = ($urandom % 3) != 0;
      prev_stall = !rdy;
      @(negedge clk);
      if (rdy) begin
        idx += (w <= 1) ? 8 : (w == 2) ? 2 : 1;
        slot = (slot + ((w == 1) ? 2 : 1)) % NFU;
        iss++;
      end
    end
    rdy = 0;
    if (idx >= n) chk(vld == 0, "R9 idle after last", vld, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vld == 0, "R1 reset vld", vld, 0);
    rst_n = 1;
    @(negedge clk);
    chk(vld == 0, "R1 idle after reset", vld, 0);
    for (int w = 0; w < 4; w++)
      for (int n = 0; n <= 20; n++)
        for (int pe = 0; pe < 2; pe++)
          for (int bs = 0; bs < 4; bs++)
            for (int inv = 0; inv < 2; inv++)
              run_op(w, n, pe[0], bs, inv[0], $urandom, 1000);
    // R9: restart while busy
    for (int w = 0; w < 4; w++) begin
      run_op(w, 19, 1, 2, 0, $urandom, 2);
      chk(vld == 1, "R9 still busy before restart", vld, 1);
      run_op(3 - w, 13, 1, 1, 1, $urandom, 1000);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule